// File: doc/BRIEF.md
# Indirect Register and Memory Access Window

This block is a host-side slave that reaches internal memory, peripheral registers and a shared register space through staged address and data registers instead of a direct mapping. The host programs an address register, then touches a data register; that data access is what launches a transaction on the internal master port. The internal port offers one request per launching access and waits for a ready response. The host access is held (no `host_ready`) until that response arrives.

Three windows exist. The memory window has separate read and write address registers, and each data access moves its address on by one 32-bit word. The peripheral window carries a 16-bit offset and a two-bit byte count in its address registers. It masks write data and zero-extends read data to that count. The shared-register window is driven by a control word that holds a target offset and an opcode. For a write, software stages the data register first. For a read, the result lands in that same data register.

Top module: `iwin_top`

## Requirements
- R1: After reset `host_ready` and `int_req` are 0 and every window register (0x40C, 0x410, 0x444, 0x448, 0xEC, 0xF4) reads back as 0.
- R2: A host write to 0x418 issues one internal write in space 0 (memory) at the address held in 0x410, with all four byte enables and the host data. Afterwards 0x410 has advanced by 4.
- R3: A host read of 0x41C issues one internal read in space 0 at the address held in 0x40C, returns `int_rdata` to the host, and advances 0x40C by 4.
- R4: A host write to 0x44C issues an internal write in space 1 (peripheral) at bits 15:0 of 0x444. Bits 25:24 of 0x444 hold N = byte count minus one: the low N+1 byte enables are set and the data bytes above them are zero. The address does not advance.
- R5: A host read of 0x450 issues an internal read in space 1 at bits 15:0 of 0x448, with byte enables from bits 25:24 of 0x448. The host receives `int_rdata` with the bytes above that count cleared.
- R6: Writing 0xEC with opcode 3 in bits 29:28 issues an internal write in space 2 (shared) at bits 15:0 of that word, carrying the value staged in 0xF4.
- R7: Writing 0xEC with opcode 2 issues an internal read in space 2 at bits 15:0. The returned word is stored in 0xF4 and read back from there.
- R8: Writing 0xEC with opcode 0 or 1 stores the word but issues no internal request and leaves 0xF4 unchanged.
- R9: `host_ready` is a one-cycle pulse per host access. It comes one cycle after acceptance for accesses that launch nothing. For a launching access it comes the cycle after the cycle in which `int_ready` is seen, and never while a request is outstanding.
- R10: `int_req` is high for exactly one cycle per launching access. `int_addr`, `int_we` and `int_space` stay stable until `int_ready`.
- R11: Reads of unmapped offsets return 0 and writes to them change no window register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until `host_ready` |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 12 | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with `host_ready` |
| host_ready | output | 1 | One-cycle completion of the host access |
| int_req | output | 1 | One-cycle internal request |
| int_we | output | 1 | Internal write (1) or read (0) |
| int_space | output | 2 | 0 memory, 1 peripheral, 2 shared |
| int_addr | output | 32 | Internal address |
| int_be | output | 4 | Internal byte enables |
| int_wdata | output | 32 | Internal write data |
| int_rdata | input | 32 | Internal read data, valid with `int_ready` |
| int_ready | input | 1 | Internal completion |

## Verification
The bench goes after these cases:
- Back-to-back memory data accesses. A design that forgot the advance, or advanced the wrong pointer, would repeat an address or move the other window's pointer.
- Peripheral byte counts of one, two, three and four bytes. Upper bits are set above the count field, so a design that decoded the field from the wrong bits would show wrong enables or leak data bytes.
- Shared-register opcodes 0 and 1. A design that treated any control write as a trigger would put a request on the internal port that nothing expects.
- Internal latencies of zero to three cycles. A design that released the host early, or pulsed `int_req` more than once, would show a wrong completion latency.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

  typedef enum logic [1:0] {
    SP_MEM  = 2'd0,
    SP_PRPH = 2'd1,
    SP_SHR  = 2'd2
  } space_e;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_RDREG,
    OP_SET_MRA,
    OP_SET_MWA,
    OP_MEM_WR,
    OP_MEM_RD,
    OP_SET_PWA,
    OP_SET_PRA,
    OP_PRPH_WR,
    OP_PRPH_RD,
    OP_SET_CTRL,
    OP_SET_SDATA,
    OP_SH_WR,
    OP_SH_RD
  } win_op_e;

  // host-visible offsets; software decodes these
  localparam logic [11:0] OFS_MRA   = 12'h40C;
  localparam logic [11:0] OFS_MWA   = 12'h410;
  localparam logic [11:0] OFS_MWDAT = 12'h418;
  localparam logic [11:0] OFS_MRDAT = 12'h41C;
  localparam logic [11:0] OFS_PWA   = 12'h444;
  localparam logic [11:0] OFS_PRA   = 12'h448;
  localparam logic [11:0] OFS_PWDAT = 12'h44C;
  localparam logic [11:0] OFS_PRDAT = 12'h450;
  localparam logic [11:0] OFS_CTRL  = 12'h0EC;
  localparam logic [11:0] OFS_SDATA = 12'h0F4;

  localparam logic [1:0] SH_OPC_RD = 2'd2;
  localparam logic [1:0] SH_OPC_WR = 2'd3;

endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
  import iwin_pkg::*;
#(
  parameter int HA_W = 12
) (
  input  logic            host_we,
  input  logic [HA_W-1:0] host_addr,
  input  logic [1:0]      opc,
  output win_op_e         op,
  output logic            trig
);

  always_comb begin
    op = OP_NONE;
    if (host_we) begin
      case (host_addr)
        HA_W'(OFS_MRA):   op = OP_SET_MRA;
        HA_W'(OFS_MWA):   op = OP_SET_MWA;
        HA_W'(OFS_MWDAT): op = OP_MEM_WR;
        HA_W'(OFS_PWA):   op = OP_SET_PWA;
        HA_W'(OFS_PRA):   op = OP_SET_PRA;
        HA_W'(OFS_PWDAT): op = OP_PRPH_WR;
        HA_W'(OFS_SDATA): op = OP_SET_SDATA;
        HA_W'(OFS_CTRL): begin
          if (opc == SH_OPC_WR)      op = OP_SH_WR;
          else if (opc == SH_OPC_RD) op = OP_SH_RD;
          else                       op = OP_SET_CTRL;
        end
        default: op = OP_NONE;
      endcase
    end else begin
      case (host_addr)
        HA_W'(OFS_MRA), HA_W'(OFS_MWA), HA_W'(OFS_PWA),
        HA_W'(OFS_PRA), HA_W'(OFS_CTRL), HA_W'(OFS_SDATA): op = OP_RDREG;
        HA_W'(OFS_MRDAT): op = OP_MEM_RD;
        HA_W'(OFS_PRDAT): op = OP_PRPH_RD;
        default:          op = OP_NONE;
      endcase
    end
  end

  assign trig = (op == OP_MEM_WR)  || (op == OP_MEM_RD)  ||
                (op == OP_PRPH_WR) || (op == OP_PRPH_RD) ||
                (op == OP_SH_WR)   || (op == OP_SH_RD);

endmodule

// File: rtl/iwin_lanes.sv
module iwin_lanes #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic [1:0]    cnt,
  output logic [NB-1:0] be,
  output logic [DW-1:0] mask
);

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign be[g]         = (g <= int'(cnt));
    assign mask[g*8 +: 8] = {8{be[g]}};
  end

endmodule

// File: rtl/iwin_xfer.sv
module iwin_xfer (
  input  logic clk,
  input  logic rst_ni,
  input  logic host_req,
  input  logic trig,
  input  logic int_ready,
  output logic accept,
  output logic done,
  output logic int_req,
  output logic host_ready
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_e;
  st_e st_q, st_d;

  assign accept     = (st_q == S_IDLE) && host_req;
  assign done       = ((st_q == S_ISSUE) || (st_q == S_WAIT)) && int_ready;
  assign int_req    = (st_q == S_ISSUE);
  assign host_ready = (st_q == S_RESP);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE:  if (host_req) st_d = trig ? S_ISSUE : S_RESP;
      S_ISSUE: st_d = int_ready ? S_RESP : S_WAIT;
      S_WAIT:  if (int_ready) st_d = S_RESP;
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/iwin_top.sv
module iwin_top
  import iwin_pkg::*;
#(
  parameter int HA_W = 12,
  parameter int DW   = 32,
  parameter int AW   = 32,
  localparam int NB  = DW / 8,
  localparam int OFS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_req,
  input  logic            host_we,
  input  logic [HA_W-1:0] host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            host_ready,
  output logic            int_req,
  output logic            int_we,
  output logic [1:0]      int_space,
  output logic [AW-1:0]   int_addr,
  output logic [NB-1:0]   int_be,
  output logic [DW-1:0]   int_wdata,
  input  logic [DW-1:0]   int_rdata,
  input  logic            int_ready
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  win_op_e op, op_q, op_d;
  logic    trig, accept, done;

  iwin_decode #(.HA_W(HA_W)) u_dec (
    .host_we(host_we), .host_addr(host_addr),
    .opc(host_wdata[29:28]), .op(op), .trig(trig)
  );

  iwin_xfer u_xfer (
    .clk(clk), .rst_ni(rst_ni), .host_req(host_req), .trig(trig),
    .int_ready(int_ready), .accept(accept), .done(done),
    .int_req(int_req), .host_ready(host_ready)
  );

  logic [AW-1:0] mra_q, mra_d, mwa_q, mwa_d;
  logic [DW-1:0] pwa_q, pwa_d, pra_q, pra_d, ctrl_q, ctrl_d, sdata_q, sdata_d;
  logic [DW-1:0] rdata_q, rdata_d, wd_q, wd_d;
  logic [AW-1:0] ad_q, ad_d;
  logic [NB-1:0] be_q, be_d;
  logic [1:0]    sp_q, sp_d;
  logic          we_q, we_d;

  logic [NB-1:0] wbe, rbe;
  logic [DW-1:0] wmask, rmask;

  iwin_lanes #(.DW(DW)) u_lane_w (.cnt(pwa_q[25:24]), .be(wbe), .mask(wmask));
  iwin_lanes #(.DW(DW)) u_lane_r (.cnt(pra_q[25:24]), .be(rbe), .mask(rmask));

  localparam logic [AW-1:0] STEP = AW'(NB);

  logic [DW-1:0] reg_rd;
  always_comb begin
    case (host_addr)
      HA_W'(OFS_MRA):   reg_rd = DW'(mra_q);
      HA_W'(OFS_MWA):   reg_rd = DW'(mwa_q);
      HA_W'(OFS_PWA):   reg_rd = pwa_q;
      HA_W'(OFS_PRA):   reg_rd = pra_q;
      HA_W'(OFS_CTRL):  reg_rd = ctrl_q;
      HA_W'(OFS_SDATA): reg_rd = sdata_q;
      default:          reg_rd = '0;
    endcase
  end

  always_comb begin
    op_d = op_q;   mra_d = mra_q;   mwa_d = mwa_q;
    pwa_d = pwa_q; pra_d = pra_q;   ctrl_d = ctrl_q; sdata_d = sdata_q;
    rdata_d = rdata_q; wd_d = wd_q; ad_d = ad_q; be_d = be_q;
    sp_d = sp_q;   we_d = we_q;
    if (accept) begin
      op_d    = op;
      rdata_d = '0;
      case (op)
        OP_RDREG:     rdata_d = reg_rd;
        OP_SET_MRA:   mra_d   = AW'(host_wdata);
        OP_SET_MWA:   mwa_d   = AW'(host_wdata);
        OP_SET_PWA:   pwa_d   = host_wdata;
        OP_SET_PRA:   pra_d   = host_wdata;
        OP_SET_SDATA: sdata_d = host_wdata;
        OP_SET_CTRL, OP_SH_WR, OP_SH_RD: ctrl_d = host_wdata;
        default: ;
      endcase
      case (op)
        OP_MEM_WR: begin
          we_d = 1'b1; sp_d = SP_MEM; ad_d = mwa_q; be_d = '1; wd_d = host_wdata;
        end
        OP_MEM_RD: begin
          we_d = 1'b0; sp_d = SP_MEM; ad_d = mra_q; be_d = '1; wd_d = '0;
        end
        OP_PRPH_WR: begin
          we_d = 1'b1; sp_d = SP_PRPH; ad_d = AW'(pwa_q[OFS_W-1:0]);
          be_d = wbe;  wd_d = host_wdata & wmask;
        end
        OP_PRPH_RD: begin
          we_d = 1'b0; sp_d = SP_PRPH; ad_d = AW'(pra_q[OFS_W-1:0]);
          be_d = rbe;  wd_d = '0;
        end
        OP_SH_WR: begin
          we_d = 1'b1; sp_d = SP_SHR; ad_d = AW'(host_wdata[OFS_W-1:0]);
          be_d = '1;   wd_d = sdata_q;
        end
        OP_SH_RD: begin
          we_d = 1'b0; sp_d = SP_SHR; ad_d = AW'(host_wdata[OFS_W-1:0]);
          be_d = '1;   wd_d = '0;
        end
        default: ;
      endcase
    end
    if (done) begin
      case (op_q)
        OP_MEM_WR:  mwa_d = mwa_q + STEP;
        OP_MEM_RD: begin
          mra_d   = mra_q + STEP;
          rdata_d = int_rdata;
        end
        OP_PRPH_RD: rdata_d = int_rdata & rmask;
        OP_SH_RD:   sdata_d = int_rdata;
        default: ;
      endcase
    end
  end

  logic upd_en;
  assign upd_en = accept | done;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q <= OP_NONE; mra_q <= '0; mwa_q <= '0; pwa_q <= '0; pra_q <= '0;
      ctrl_q <= '0; sdata_q <= '0; rdata_q <= '0; wd_q <= '0; ad_q <= '0;
      be_q <= '0; sp_q <= '0; we_q <= 1'b0;
    end else if (upd_en) begin
      op_q <= op_d; mra_q <= mra_d; mwa_q <= mwa_d; pwa_q <= pwa_d; pra_q <= pra_d;
      ctrl_q <= ctrl_d; sdata_q <= sdata_d; rdata_q <= rdata_d; wd_q <= wd_d;
      ad_q <= ad_d; be_q <= be_d; sp_q <= sp_d; we_q <= we_d;
    end
  end

  assign host_rdata = rdata_q;
  assign int_we     = we_q;
  assign int_space  = sp_q;
  assign int_addr   = ad_q;
  assign int_be     = be_q;
  assign int_wdata  = wd_q;

endmodule

// File: rtl/iwin_chk.sv
module iwin_chk #(
  parameter int AW = 32,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_ready,
  input logic          int_req,
  input logic          int_ready,
  input logic          int_we,
  input logic [1:0]    int_space,
  input logic [AW-1:0] int_addr,
  input logic [NB-1:0] int_be
);

  logic outstanding;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     outstanding <= 1'b0;
    else if (int_req && !int_ready) outstanding <= 1'b1;
    else if (int_ready)             outstanding <= 1'b0;
  end

  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  a_r9_no_ready_pending: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !host_ready);

  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ready && (int_req || outstanding)) |=> host_ready);

  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |=> !int_req);

  a_r10_no_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !int_req);

  a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> ($stable(int_addr) && $stable(int_we) && $stable(int_space)));

  a_r2_full_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_space == 2'd0) |-> (&int_be));

  a_r4_lanes_contig: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int_space == 2'd1) |-> (int_be[0] && $onehot({1'b0, int_be} + 1'b1)));

endmodule

bind iwin_top iwin_chk #(.AW(AW), .NB(NB)) u_chk (.*);

// File: tb/sim_iwin_top.sv
`timescale 1ns/1ps
module sim_iwin_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [11:0] host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        host_ready;
  logic        int_req, int_we;
  logic [1:0]  int_space;
  logic [31:0] int_addr, int_wdata, int_rdata;
  logic [3:0]  int_be;
  logic        int_ready;

  always #2.5 clk = ~clk;

  iwin_top u0 (.*);

  typedef struct {
    logic        we;
    logic [1:0]  sp;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  int          n_chk = 0, n_err = 0;
  int          lat_cfg = 0;
  logic [31:0] resp_data = '0;
  logic [31:0] rd;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [1:0] sp, input logic [31:0] a,
                      input logic [3:0] be, input logic [31:0] wd, input string tag);
    exp_t e;
    e.we = we; e.sp = sp; e.addr = a; e.be = be; e.wd = wd; e.tag = tag;
    expq.push_back(e);
  endtask

  // host driver: returns read data, checks completion latency
  task automatic acc(input bit we, input logic [11:0] a, input logic [31:0] wd,
                     input int exp_lat, input string tag, output logic [31:0] r);
    int cnt;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!host_ready && cnt < 100);
    r = host_rdata;
    host_req = 1'b0;
    chk(cnt == exp_lat, "R9", {tag, " completion latency"}, cnt, exp_lat);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input int exp_lat,
                    input string tag);
    logic [31:0] dummy;
    acc(1'b1, a, wd, exp_lat, tag, dummy);
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input int exp_lat,
                        input string tag);
    logic [31:0] r;
    acc(1'b0, a, 32'h0, exp_lat, tag, r);
    chk(r === exp, tag, $sformatf("read of %h", a), r, exp);
  endtask

  // monitor and internal responder
  int wait_cnt = 0;
  bit pend = 0;
  always @(negedge clk) begin
    int_ready = 1'b0;
    if (pend) begin
      if (wait_cnt == 0) begin
        int_ready = 1'b1; int_rdata = resp_data; pend = 0;
      end else wait_cnt--;
    end
    if (rst_n && int_req) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8", "unexpected internal request addr", int_addr, 32'h0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(int_we === e.we, e.tag, "int_we", 32'(int_we), 32'(e.we));
        chk(int_space === e.sp, e.tag, "int_space", 32'(int_space), 32'(e.sp));
        chk(int_addr === e.addr, e.tag, "int_addr", int_addr, e.addr);
        chk(int_be === e.be, e.tag, "int_be", 32'(int_be), 32'(e.be));
        if (e.we) chk(int_wdata === e.wd, e.tag, "int_wdata", int_wdata, e.wd);
      end
      if (lat_cfg == 0) begin
        int_ready = 1'b1; int_rdata = resp_data;
      end else begin
        pend = 1; wait_cnt = lat_cfg - 1;
      end
    end
  end

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog: actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_wdata = '0; int_rdata = '0; int_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(host_ready === 1'b0, "R1", "host_ready in reset", 32'(host_ready), 32'h0);
    chk(int_req === 1'b0, "R1", "int_req in reset", 32'(int_req), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 readback after reset
    rd_chk(12'h40C, 32'h0, 1, "R1");
    rd_chk(12'h410, 32'h0, 1, "R1");
    rd_chk(12'h444, 32'h0, 1, "R1");
    rd_chk(12'h448, 32'h0, 1, "R1");
    rd_chk(12'h0EC, 32'h0, 1, "R1");
    rd_chk(12'h0F4, 32'h0, 1, "R1");

    // R2 memory writes with auto-advance
    lat_cfg = 0;
    wr(12'h410, 32'h0000_0100, 1, "R2");
    push(1'b1, 2'd0, 32'h100, 4'hF, 32'hAAAA_0001, "R2");
    wr(12'h418, 32'hAAAA_0001, 2, "R2");
    lat_cfg = 1;
    push(1'b1, 2'd0, 32'h104, 4'hF, 32'h0000_0002, "R2");
    wr(12'h418, 32'h0000_0002, 3, "R2");
    rd_chk(12'h410, 32'h108, 1, "R2");

    // R3 memory reads with auto-advance
    wr(12'h40C, 32'h0000_0200, 1, "R3");
    lat_cfg = 2; resp_data = 32'h1111_2222;
    push(1'b0, 2'd0, 32'h200, 4'hF, 32'h0, "R3");
    rd_chk(12'h41C, 32'h1111_2222, 4, "R3");
    lat_cfg = 0; resp_data = 32'h0000_0033;
    push(1'b0, 2'd0, 32'h204, 4'hF, 32'h0, "R3");
    rd_chk(12'h41C, 32'h0000_0033, 2, "R3");
    rd_chk(12'h40C, 32'h208, 1, "R3");
    rd_chk(12'h410, 32'h108, 1, "R3");

    // R4 peripheral writes, byte-count masking, no advance
    wr(12'h444, 32'h0100_1234, 1, "R4");
    push(1'b1, 2'd1, 32'h1234, 4'h3, 32'h0000_BEEF, "R4");
    wr(12'h44C, 32'hDEAD_BEEF, 2, "R4");
    push(1'b1, 2'd1, 32'h1234, 4'h3, 32'h0000_5678, "R4");
    wr(12'h44C, 32'h1234_5678, 2, "R4");
    wr(12'h444, 32'h0300_0040, 1, "R4");
    push(1'b1, 2'd1, 32'h40, 4'hF, 32'hCAFE_F00D, "R4");
    wr(12'h44C, 32'hCAFE_F00D, 2, "R4");
    wr(12'h444, 32'hFCFF_0010, 1, "R4");
    push(1'b1, 2'd1, 32'h10, 4'h1, 32'h0000_000D, "R4");
    wr(12'h44C, 32'hCAFE_F00D, 2, "R4");

    // R5 peripheral read zero-extension
    wr(12'h448, 32'h0200_0ABC, 1, "R5");
    lat_cfg = 1; resp_data = 32'hFFEE_DDCC;
    push(1'b0, 2'd1, 32'hABC, 4'h7, 32'h0, "R5");
    rd_chk(12'h450, 32'h00EE_DDCC, 3, "R5");

    // R6 shared write
    lat_cfg = 0;
    wr(12'h0F4, 32'h5A5A_5A5A, 1, "R6");
    push(1'b1, 2'd2, 32'h1DC, 4'hF, 32'h5A5A_5A5A, "R6");
    wr(12'h0EC, 32'h3000_01DC, 2, "R6");

    // R7 shared read into the data register
    lat_cfg = 3; resp_data = 32'h8765_4321;
    push(1'b0, 2'd2, 32'h55, 4'hF, 32'h0, "R7");
    wr(12'h0EC, 32'h2000_0055, 5, "R7");
    rd_chk(12'h0F4, 32'h8765_4321, 1, "R7");

    // R8 ignored opcodes: no request, data register kept
    resp_data = 32'h0BAD_0BAD;
    wr(12'h0EC, 32'h1000_0077, 1, "R8");
    wr(12'h0EC, 32'h0000_0078, 1, "R8");
    rd_chk(12'h0F4, 32'h8765_4321, 1, "R8");
    rd_chk(12'h0EC, 32'h0000_0078, 1, "R8");

    // R11 unmapped offsets
    wr(12'h000, 32'hFFFF_FFFF, 1, "R11");
    rd_chk(12'h000, 32'h0, 1, "R11");
    rd_chk(12'h418, 32'h0, 1, "R11");
    rd_chk(12'h40C, 32'h208, 1, "R11");
    rd_chk(12'h444, 32'hFCFF_0010, 1, "R11");

    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R10", "pending expected requests", expq.size(), 32'h0);
    finish_run();
  end

endmodule